// File: doc/BRIEF.md
# Latching Status Management Register Bank

This block is the register file behind a serial management bus, seen after the bus framing has been decoded into single-cycle transactions. Each transaction has a port address, a device number, a 16-bit address, 16-bit data, and a read or write strobe. The block answers only on port 0. Device 0 reaches a generic chip bank. Devices 1 to 3 reach three identical macro banks, each serving a physical-layer macro with up to two lanes. The bank behind device 1 drives a single-lane macro, so its lane-1 registers are absent.

Registers are 8 bits wide. They sit in the low byte of the 16-bit address and data fields, and the high bytes must be zero. The banks hold read/write control fields, a read-only identifier, and a 5-bit divider field. Each macro lane reports status through two bits: a link-good bit that latches low and an error bit that latches high. A latched value holds until the register is read. Action bits clear themselves: a write of 1 raises a start output, and a done input clears it.

Register map. Generic bank: 0x00 identifier (read-only, 0x5A); 0x01 scratch (R/W); 0x02 divider, bits [4:0] (R/W); 0x03 bit 0 action start (self-clearing). Macro bank: 0x00 common control (R/W); 0x01 and 0x02 lane 0 and lane 1 control (R/W); 0x10 and 0x11 lane 0 and lane 1 status, with bit 0 as link-good (latching low) and bit 1 as error (latching high); 0x20 bit 0 calibrate start (self-clearing).

Top module: `mgmt_regbank`

## Requirements
- R1: A transaction whose port address is not 0 has no effect. A read returns 0x0000, a write changes no register, and latched status bits are not released.
- R2: Device 0 selects the generic bank and devices 1, 2 and 3 select macro banks 0, 1 and 2. Device numbers above 3 read 0x0000 and ignore writes.
- R3: Only addresses with a zero upper byte are mapped. Read data always has a zero upper byte. A write whose data upper byte is non-zero is ignored.
- R4: Status bit 0 (link-good) drops to 0 when its input goes low. It stays 0 until that status register is read, and afterwards follows the input.
- R5: Status bit 1 (error) rises to 1 when its input goes high. It stays 1 until that status register is read, and afterwards follows the input.
- R6: Writing 1 to an action bit sets it and raises its start output. The bit stays set until its done input is high, then clears. Writing 0 has no effect.
- R7: The divider at generic 0x02 keeps only bits [4:0]. The upper three bits are forced to 0 on write and read back as 0.
- R8: In the device 1 bank, the lane-1 registers 0x02 and 0x11 read 0x0000, ignore writes, and keep lane-1 control output at 0. Lane 0 works normally.
- R9: Unmapped addresses read 0x0000. Writes to unmapped addresses, to the identifier and to status registers have no effect.
- R10: Read data appears in the cycle after the read strobe and is 0x0000 in any cycle not following an accepted read.
- R11: After reset, all control outputs, start outputs, scratch, divider and read data are 0.
- R12: If a latching event occurs in the same cycle as a read of its register, the read returns the latched value and the latch stays set for the following read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mg_rd | input | 1 | Read strobe |
| mg_wr | input | 1 | Write strobe |
| mg_port | input | 5 | Port address of the transaction |
| mg_dev | input | 5 | Device number |
| mg_addr | input | 16 | Register address |
| mg_wdata | input | 16 | Write data |
| mg_rdata | output | 16 | Read data, one cycle after the read strobe |
| gen_scratch | output | 8 | Generic scratch register |
| gen_div | output | 5 | Generic divider field |
| gen_act_start | output | 1 | Generic action start |
| gen_act_done | input | 1 | Generic action completion |
| mac_ctrl | output | 24 | Common control, 8 bits per macro |
| mac_lane_ctrl | output | 48 | Lane control; macro m, lane l at bits (2m+l)*8 |
| mac_link_ok | input | 6 | Live link-good per macro lane, index 2m+l |
| mac_err | input | 6 | Live error per macro lane, index 2m+l |
| mac_cal_start | output | 3 | Calibrate start per macro |
| mac_cal_done | input | 3 | Calibrate completion per macro |

## Verification
The bench targets latch release. If a read with a foreign port released a latch, a later valid read would lose a held error. If an event during a read cleared the latch, the second read of R12 would miss it. It checks that device 1 lane-1 writes and device numbers above 3 are ignored: a design that aliases devices would show another bank's value. It also checks write data with a non-zero upper byte and writes of 0 to action bits, either of which a careless decoder would accept.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int REG_W  = 8;
  localparam int MG_W   = 16;
  localparam int PORT_W = 5;
  localparam int DEV_W  = 5;
  localparam int LANES  = 2;
  localparam int DIV_W  = 5;

  // generic bank offsets
  localparam logic [REG_W-1:0] G_ID      = 8'h00;
  localparam logic [REG_W-1:0] G_SCRATCH = 8'h01;
  localparam logic [REG_W-1:0] G_DIV     = 8'h02;
  localparam logic [REG_W-1:0] G_ACT     = 8'h03;
  // macro bank offsets (lane k at base + k)
  localparam logic [REG_W-1:0] M_CTRL    = 8'h00;
  localparam logic [REG_W-1:0] M_LCTL    = 8'h01;
  localparam logic [REG_W-1:0] M_STAT    = 8'h10;
  localparam logic [REG_W-1:0] M_CAL     = 8'h20;

  // value seen by software for a latching bit
  function automatic logic lat_view(input bit hold_low, input logic live, input logic held);
    return hold_low ? (live & ~held) : (live | held);
  endfunction

  // next state of the latch flag: set by an event, released by a read
  function automatic logic lat_next(input bit hold_low, input logic live,
                                    input logic held, input logic rd);
    logic evt;
    evt = hold_low ? ~live : live;
    return evt | (held & ~rd);
  endfunction

  // self-clearing bit: a new start wins over completion
  function automatic logic sc_next(input logic set, input logic done, input logic cur);
    return set ? 1'b1 : (done ? 1'b0 : cur);
  endfunction
endpackage

// File: rtl/mgmt_latch.sv
module mgmt_latch
  import mgmt_pkg::*;
#(
  parameter bit HOLD_LOW = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic live_i,
  input  logic rd_i,
  output logic value_o
);
  logic held_q;

  assign value_o = lat_view(HOLD_LOW, live_i, held_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= lat_next(HOLD_LOW, live_i, held_q, rd_i);
  end

  generate
    if (HOLD_LOW) begin : g_low
      AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && !value_o) |=> !value_o); // R4
    end else begin : g_high
      AST_HIGH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && value_o) |=> value_o); // R5
    end
  endgenerate
endmodule

// File: rtl/mgmt_gen_bank.sv
module mgmt_gen_bank
  import mgmt_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'h5A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rd_val_o,
  output logic [REG_W-1:0] scratch_o,
  output logic [DIV_W-1:0] div_o,
  output logic             act_start_o,
  input  logic             act_done_i
);
  logic [REG_W-1:0] scratch_q;
  logic [DIV_W-1:0] div_q;
  logic             act_q;
  logic             act_set;

  assign act_set = wr_i && (addr_i == G_ACT) && wdata_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
      div_q     <= '0;
      act_q     <= 1'b0;
    end else begin
      if (wr_i && addr_i == G_SCRATCH) scratch_q <= wdata_i;
      if (wr_i && addr_i == G_DIV)     div_q     <= wdata_i[DIV_W-1:0];
      act_q <= sc_next(act_set, act_done_i, act_q);
    end
  end

  always_comb begin
    rd_val_o = '0;
    case (addr_i)
      G_ID:      rd_val_o = CHIP_ID;
      G_SCRATCH: rd_val_o = scratch_q;
      G_DIV:     rd_val_o = REG_W'(div_q);
      G_ACT:     rd_val_o = REG_W'(act_q);
      default:   rd_val_o = '0;
    endcase
  end

  assign scratch_o   = scratch_q;
  assign div_o       = div_q;
  assign act_start_o = act_q;

  AST_ACT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (act_start_o && !act_done_i) |=> act_start_o); // R6
  AST_ACT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (act_start_o && act_done_i && !act_set) |=> !act_start_o); // R6
endmodule

// File: rtl/mgmt_macro_bank.sv
module mgmt_macro_bank
  import mgmt_pkg::*;
#(
  parameter bit SINGLE_LANE = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_i,
  input  logic                   rd_i,
  input  logic [REG_W-1:0]       addr_i,
  input  logic [REG_W-1:0]       wdata_i,
  output logic [REG_W-1:0]       rd_val_o,
  output logic [REG_W-1:0]       ctrl_o,
  output logic [LANES*REG_W-1:0] lane_ctrl_o,
  input  logic [LANES-1:0]       link_ok_i,
  input  logic [LANES-1:0]       err_i,
  output logic                   cal_start_o,
  input  logic                   cal_done_i
);
  function automatic bit lane_live(input int k);
    return !(SINGLE_LANE && k != 0);
  endfunction

  logic [REG_W-1:0]       ctrl_q;
  logic [LANES*REG_W-1:0] lctl_q;
  logic [LANES-1:0]       ok_v, err_v, stat_rd;
  logic                   cal_q, cal_set;

  assign cal_set = wr_i && (addr_i == M_CAL) && wdata_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lctl_q <= '0;
      cal_q  <= 1'b0;
    end else begin
      if (wr_i && addr_i == M_CTRL) ctrl_q <= wdata_i;
      for (int k = 0; k < LANES; k++)
        if (wr_i && lane_live(k) && addr_i == REG_W'(M_LCTL + k))
          lctl_q[k*REG_W +: REG_W] <= wdata_i;
      cal_q <= sc_next(cal_set, cal_done_i, cal_q);
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign stat_rd[l] = rd_i && lane_live(l) && addr_i == REG_W'(M_STAT + l);
    mgmt_latch #(.HOLD_LOW(1'b1)) i_ok (
      .clk(clk), .rst_n(rst_n), .live_i(link_ok_i[l]), .rd_i(stat_rd[l]), .value_o(ok_v[l]));
    mgmt_latch #(.HOLD_LOW(1'b0)) i_err (
      .clk(clk), .rst_n(rst_n), .live_i(err_i[l]), .rd_i(stat_rd[l]), .value_o(err_v[l]));
  end

  always_comb begin
    rd_val_o = '0;
    if (addr_i == M_CTRL) rd_val_o = ctrl_q;
    if (addr_i == M_CAL)  rd_val_o = REG_W'(cal_q);
    for (int k = 0; k < LANES; k++) begin
      if (addr_i == REG_W'(M_LCTL + k)) rd_val_o = lctl_q[k*REG_W +: REG_W];
      if (addr_i == REG_W'(M_STAT + k) && lane_live(k))
        rd_val_o = {6'b0, err_v[k], ok_v[k]};
    end
  end

  assign ctrl_o      = ctrl_q;
  assign lane_ctrl_o = lctl_q;
  assign cal_start_o = cal_q;

  AST_CAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_start_o && !cal_done_i) |=> cal_start_o); // R6
  AST_CAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_start_o && cal_done_i && !cal_set) |=> !cal_start_o); // R6
endmodule

// File: rtl/mgmt_regbank.sv
module mgmt_regbank
  import mgmt_pkg::*;
#(
  parameter int         N_MACRO = 3,
  parameter logic [7:0] CHIP_ID = 8'h5A
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           mg_rd,
  input  logic                           mg_wr,
  input  logic [PORT_W-1:0]              mg_port,
  input  logic [DEV_W-1:0]               mg_dev,
  input  logic [MG_W-1:0]                mg_addr,
  input  logic [MG_W-1:0]                mg_wdata,
  output logic [MG_W-1:0]                mg_rdata,
  output logic [REG_W-1:0]               gen_scratch,
  output logic [DIV_W-1:0]               gen_div,
  output logic                           gen_act_start,
  input  logic                           gen_act_done,
  output logic [N_MACRO*REG_W-1:0]       mac_ctrl,
  output logic [N_MACRO*LANES*REG_W-1:0] mac_lane_ctrl,
  input  logic [N_MACRO*LANES-1:0]       mac_link_ok,
  input  logic [N_MACRO*LANES-1:0]       mac_err,
  output logic [N_MACRO-1:0]             mac_cal_start,
  input  logic [N_MACRO-1:0]             mac_cal_done
);
  localparam int HI_W = MG_W - REG_W;

  logic             addr_ok;     // port 0 and upper address byte clear
  logic             wr_hit;      // accepted write
  logic             rd_hit;      // accepted read
  logic [REG_W-1:0] reg_addr, reg_wdata, gen_val, sel_val;
  logic [REG_W-1:0] mac_val [N_MACRO];

  assign addr_ok   = (mg_port == '0) && (mg_addr[MG_W-1:REG_W] == '0);
  assign wr_hit    = mg_wr && addr_ok && (mg_wdata[MG_W-1:REG_W] == '0);
  assign rd_hit    = mg_rd && addr_ok;
  assign reg_addr  = mg_addr[REG_W-1:0];
  assign reg_wdata = mg_wdata[REG_W-1:0];

  mgmt_gen_bank #(.CHIP_ID(CHIP_ID)) i_gen (
    .clk(clk), .rst_n(rst_n),
    .wr_i(wr_hit && mg_dev == '0),
    .addr_i(reg_addr), .wdata_i(reg_wdata), .rd_val_o(gen_val),
    .scratch_o(gen_scratch), .div_o(gen_div),
    .act_start_o(gen_act_start), .act_done_i(gen_act_done));

  for (genvar m = 0; m < N_MACRO; m++) begin : g_mac
    logic dev_sel;
    assign dev_sel = (mg_dev == DEV_W'(m + 1));
    mgmt_macro_bank #(.SINGLE_LANE(m == 0)) i_mac (
      .clk(clk), .rst_n(rst_n),
      .wr_i(wr_hit && dev_sel), .rd_i(rd_hit && dev_sel),
      .addr_i(reg_addr), .wdata_i(reg_wdata), .rd_val_o(mac_val[m]),
      .ctrl_o(mac_ctrl[m*REG_W +: REG_W]),
      .lane_ctrl_o(mac_lane_ctrl[m*LANES*REG_W +: LANES*REG_W]),
      .link_ok_i(mac_link_ok[m*LANES +: LANES]),
      .err_i(mac_err[m*LANES +: LANES]),
      .cal_start_o(mac_cal_start[m]), .cal_done_i(mac_cal_done[m]));
  end

  always_comb begin
    sel_val = '0;
    if (mg_dev == '0) sel_val = gen_val;
    for (int m = 0; m < N_MACRO; m++)
      if (mg_dev == DEV_W'(m + 1)) sel_val = mac_val[m];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mg_rdata <= '0;
    else if (rd_hit) mg_rdata <= {{HI_W{1'b0}}, sel_val};
    else             mg_rdata <= '0;
  end

  AST_FOREIGN_PORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mg_rd && mg_port != '0) |=> (mg_rdata == '0)); // R1
  AST_FAR_DEV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mg_rd && mg_dev > DEV_W'(N_MACRO)) |=> (mg_rdata == '0)); // R2
  AST_HIGH_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mg_rd && mg_addr[MG_W-1:REG_W] != '0) |=> (mg_rdata == '0)); // R3
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mg_rd |=> (mg_rdata == '0)); // R10
endmodule

// File: tb/test_mgmt_regbank.sv
`timescale 1ns/1ps
module test_mgmt_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mg_rd = 1'b0, mg_wr = 1'b0;
  logic [4:0]  mg_port = '0, mg_dev = '0;
  logic [15:0] mg_addr = '0, mg_wdata = '0;
  logic [15:0] mg_rdata;
  logic [7:0]  gen_scratch;
  logic [4:0]  gen_div;
  logic        gen_act_start, gen_act_done = 1'b0;
  logic [23:0] mac_ctrl;
  logic [47:0] mac_lane_ctrl;
  logic [5:0]  mac_link_ok = 6'h3F, mac_err = 6'h00;
  logic [2:0]  mac_cal_start, mac_cal_done = 3'b000;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mgmt_regbank i_mgmt_regbank (
    .clk(clk), .rst_n(rst_n), .mg_rd(mg_rd), .mg_wr(mg_wr), .mg_port(mg_port),
    .mg_dev(mg_dev), .mg_addr(mg_addr), .mg_wdata(mg_wdata), .mg_rdata(mg_rdata),
    .gen_scratch(gen_scratch), .gen_div(gen_div), .gen_act_start(gen_act_start),
    .gen_act_done(gen_act_done), .mac_ctrl(mac_ctrl), .mac_lane_ctrl(mac_lane_ctrl),
    .mac_link_ok(mac_link_ok), .mac_err(mac_err), .mac_cal_start(mac_cal_start),
    .mac_cal_done(mac_cal_done));

  // {wr, port, dev, addr, data, expected read, requirement number}
  localparam int NV = 32;
  localparam logic [62:0] VEC [NV] = '{
    {1'b0, 5'd0, 5'd0, 16'h0000, 16'h0000, 16'h005A, 4'd2},  // R2 identifier
    {1'b1, 5'd0, 5'd0, 16'h0001, 16'h0033, 16'h0000, 4'd2},
    {1'b0, 5'd0, 5'd0, 16'h0001, 16'h0000, 16'h0033, 4'd2},
    {1'b1, 5'd0, 5'd0, 16'h0002, 16'h00FF, 16'h0000, 4'd7},  // R7 divider mask
    {1'b0, 5'd0, 5'd0, 16'h0002, 16'h0000, 16'h001F, 4'd7},
    {1'b1, 5'd0, 5'd0, 16'h0000, 16'h0011, 16'h0000, 4'd9},  // R9 read-only
    {1'b0, 5'd0, 5'd0, 16'h0000, 16'h0000, 16'h005A, 4'd9},
    {1'b1, 5'd1, 5'd0, 16'h0001, 16'h0077, 16'h0000, 4'd1},  // R1 foreign port write
    {1'b0, 5'd0, 5'd0, 16'h0001, 16'h0000, 16'h0033, 4'd1},
    {1'b0, 5'd1, 5'd0, 16'h0000, 16'h0000, 16'h0000, 4'd1},
    {1'b1, 5'd0, 5'd2, 16'h0000, 16'h00C3, 16'h0000, 4'd2},
    {1'b1, 5'd0, 5'd3, 16'h0000, 16'h003C, 16'h0000, 4'd2},
    {1'b0, 5'd0, 5'd2, 16'h0000, 16'h0000, 16'h00C3, 4'd2},
    {1'b0, 5'd0, 5'd3, 16'h0000, 16'h0000, 16'h003C, 4'd2},
    {1'b1, 5'd0, 5'd1, 16'h0002, 16'h0055, 16'h0000, 4'd8},  // R8 lane 1 absent
    {1'b0, 5'd0, 5'd1, 16'h0002, 16'h0000, 16'h0000, 4'd8},
    {1'b1, 5'd0, 5'd2, 16'h0002, 16'h0066, 16'h0000, 4'd8},
    {1'b0, 5'd0, 5'd2, 16'h0002, 16'h0000, 16'h0066, 4'd8},
    {1'b1, 5'd0, 5'd4, 16'h0000, 16'h0011, 16'h0000, 4'd2},  // R2 device 4
    {1'b0, 5'd0, 5'd4, 16'h0000, 16'h0000, 16'h0000, 4'd2},
    {1'b1, 5'd0, 5'd0, 16'h0101, 16'h0044, 16'h0000, 4'd3},  // R3 upper bytes
    {1'b0, 5'd0, 5'd0, 16'h0101, 16'h0000, 16'h0000, 4'd3},
    {1'b1, 5'd0, 5'd0, 16'h0001, 16'h1299, 16'h0000, 4'd3},
    {1'b0, 5'd0, 5'd0, 16'h0001, 16'h0000, 16'h0033, 4'd3},
    {1'b0, 5'd0, 5'd2, 16'h0010, 16'h0000, 16'h0001, 4'd4},  // R4 idle status
    {1'b0, 5'd0, 5'd1, 16'h0011, 16'h0000, 16'h0000, 4'd8},
    {1'b0, 5'd0, 5'd0, 16'h007F, 16'h0000, 16'h0000, 4'd9},  // R9 unmapped
    {1'b1, 5'd0, 5'd2, 16'h0010, 16'h00FF, 16'h0000, 4'd9},
    {1'b0, 5'd0, 5'd2, 16'h0010, 16'h0000, 16'h0001, 4'd9},
    {1'b1, 5'd0, 5'd1, 16'h0001, 16'h00AA, 16'h0000, 4'd2},
    {1'b0, 5'd0, 5'd1, 16'h0001, 16'h0000, 16'h00AA, 4'd2},
    {1'b0, 5'd0, 5'd1, 16'h0010, 16'h0000, 16'h0001, 4'd8}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one transaction; returns at the negedge where read data is valid
  task automatic op(input logic w, input logic [4:0] port, input logic [4:0] dev,
                    input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    mg_wr = w; mg_rd = ~w; mg_port = port; mg_dev = dev; mg_addr = a; mg_wdata = d;
    @(negedge clk);
    mg_wr = 1'b0; mg_rd = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] port, input logic [4:0] dev,
                        input logic [15:0] a, input logic [15:0] exp);
    op(1'b0, port, dev, a, 16'h0);
    check(tag, 64'(mg_rdata), 64'(exp));
  endtask

  task automatic pulse_err(input int idx);
    @(negedge clk); mac_err[idx] = 1'b1;
    @(negedge clk); mac_err[idx] = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 rdata", 64'(mg_rdata), 64'h0);
    check("R11 outputs", {gen_scratch, gen_div, gen_act_start, mac_cal_start},
          64'h0);
    check("R11 ctrl", {mac_ctrl, mac_lane_ctrl}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [62:0] v;
      v = VEC[i];
      op(v[62], v[61:57], v[56:52], v[51:36], v[35:20]);
      if (!v[62]) check($sformatf("R%0d vector %0d", v[3:0], i), 64'(mg_rdata), 64'(v[19:4]));
    end

    // R10: idle cycle after a read gives zero
    rd_chk("R10 read", 5'd0, 5'd0, 16'h0001, 16'h0033);
    @(negedge clk);
    check("R10 idle", 64'(mg_rdata), 64'h0);

    check("R2 R7 generic outputs", {gen_scratch, gen_div}, {8'h33, 5'h1F});
    check("R2 macro ctrl", 64'(mac_ctrl), 64'h3CC300);
    check("R8 lane ctrl", 64'(mac_lane_ctrl), 64'h0000_6600_00AA);

    // R4 latching low on macro 2 lane 1 (device 3, reg 0x11)
    @(negedge clk); mac_link_ok[5] = 1'b0;
    @(negedge clk); mac_link_ok[5] = 1'b1;
    rd_chk("R4 held low", 5'd0, 5'd3, 16'h0011, 16'h0000);
    rd_chk("R4 released", 5'd0, 5'd3, 16'h0011, 16'h0001);

    // R5 latching high on macro 1 lane 0 (device 2, reg 0x10)
    pulse_err(2);
    rd_chk("R5 held high", 5'd0, 5'd2, 16'h0010, 16'h0003);
    rd_chk("R5 released", 5'd0, 5'd2, 16'h0010, 16'h0001);

    // R1: foreign-port read does not release the latch
    pulse_err(2);
    rd_chk("R1 foreign read", 5'd3, 5'd2, 16'h0010, 16'h0000);
    rd_chk("R1 latch kept", 5'd0, 5'd2, 16'h0010, 16'h0003);
    rd_chk("R1 latch then free", 5'd0, 5'd2, 16'h0010, 16'h0001);

    // R12: event in the read cycle
    @(negedge clk);
    mac_err[2] = 1'b1;
    mg_rd = 1'b1; mg_port = 5'd0; mg_dev = 5'd2; mg_addr = 16'h0010;
    @(negedge clk);
    mg_rd = 1'b0; mac_err[2] = 1'b0;
    check("R12 coincident read", 64'(mg_rdata), 64'h0003);
    rd_chk("R12 latch kept", 5'd0, 5'd2, 16'h0010, 16'h0003);
    rd_chk("R12 then free", 5'd0, 5'd2, 16'h0010, 16'h0001);

    // R6 generic action
    op(1'b1, 5'd0, 5'd0, 16'h0003, 16'h0001);
    check("R6 start raised", 64'(gen_act_start), 64'h1);
    op(1'b1, 5'd0, 5'd0, 16'h0003, 16'h0000);
    repeat (3) @(negedge clk);
    check("R6 start held", 64'(gen_act_start), 64'h1);
    rd_chk("R6 readback", 5'd0, 5'd0, 16'h0003, 16'h0001);
    @(negedge clk); gen_act_done = 1'b1;
    @(negedge clk); gen_act_done = 1'b0;
    check("R6 start cleared", 64'(gen_act_start), 64'h0);
    rd_chk("R6 readback clear", 5'd0, 5'd0, 16'h0003, 16'h0000);

    // R6 macro calibrate on device 2
    op(1'b1, 5'd0, 5'd2, 16'h0020, 16'h0001);
    check("R6 cal start", 64'(mac_cal_start), 64'h2);
    @(negedge clk); mac_cal_done[1] = 1'b1;
    @(negedge clk); mac_cal_done[1] = 1'b0;
    check("R6 cal cleared", 64'(mac_cal_start), 64'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule